// File: doc/BRIEF.md
# Region Address Match Unit

This block keeps a small table of protection entries and says, for any physical address, which of them cover it. Each entry has an 8-bit configuration byte and a word-granular address register. A two-bit mode field in the configuration byte picks how the address register is read. The entry can be off. It can be the upper end of a span whose lower end is the previous entry's address register. It can be one naturally aligned four-byte word. It can be a naturally aligned power-of-two region whose size is given by the trailing ones of the address register.

Software-side logic writes the table through a single write port. The `wr_target` pin selects the packed configuration words (four bytes per word) or one address register. Byte enables pick the bytes that change. The lookup port is purely combinational and has no handshake. The lookup can be presented on any cycle, and the result is valid in the same cycle against the table state as of the last clock edge. It returns a per-entry match vector and a hit flag. It also returns the index of the lowest-numbered matching entry and that entry's configuration byte, which a permission stage downstream decodes.

Top module: `region_match_unit`

## Requirements
- R1: After reset every configuration byte and address register is zero, so no entry matches any address: `hit`=0, `hit_idx`=0, `hit_cfg`=0, `match_vec`=0.
- R2: A configuration write (`wr_target`=0) to word `w` stores data byte `b` into entry 4·w+b only when `wr_be[b]` is 1. The mode field is bits [4:3] of the byte: 0 off, 1 range-top, 2 single word, 3 power-of-two.
- R3: An address write (`wr_target`=1) to entry `wr_idx` changes only the bytes whose `wr_be` bit is 1. The register value is compared against `lk_addr[33:2]`. Bits above `ADDR_IMPL` always hold zero.
- R4: An entry in mode 0 matches no address, whatever its address register holds.
- R5: In range-top mode, entry i>0 matches when addr[i-1] ≤ lk_addr[33:2] < addr[i]. Entry 0 uses zero as its lower bound.
- R6: A range-top entry whose lower bound is greater than or equal to its upper bound matches nothing.
- R7: In single-word mode, the entry matches only when lk_addr[33:2] equals its address register.
- R8: In power-of-two mode, an address register ending in k ones above a zero covers 2^(k+3) bytes. Word-address bits [k:0] are ignored in the compare.
- R9: When several entries match, `hit_idx` and `hit_cfg` come from the lowest-numbered one. With no match, both are zero.
- R10: `match_vec` bit i is 1 exactly when entry i matches.
- R11: The lookup is combinational. A write takes effect at the clock edge that accepts it, and a lookup in the same cycle still sees the old table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_target | input | 1 | 0: configuration word, 1: address register |
| wr_idx | input | 4 | Configuration word index or entry index |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte enables |
| lk_addr | input | 34 | Physical byte address to look up |
| hit | output | 1 | Some entry matches |
| hit_idx | output | 4 | Lowest matching entry |
| hit_cfg | output | 8 | Configuration byte of that entry |
| match_vec | output | 16 | One bit per entry that matches |

## Verification
A table write and a lookup can land in the same cycle, and the design must then answer from the old table. The bench provokes this by moving a power-of-two region onto the looked-up address in the same cycle the lookup is driven. It samples before the edge and expects a miss. It samples again after the edge and expects a hit on the moved entry. Priority among overlapping entries is also judged in the same cycle as the full match vector. It is checked against the vector before and after the lower entry is switched off.

// File: rtl/rmu_pkg.sv
package rmu_pkg;
  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  localparam int MODE_LSB = 3;

  function automatic amode_e mode_of(input logic [7:0] cfg);
    return amode_e'(cfg[MODE_LSB +: 2]);
  endfunction
endpackage

// File: rtl/rmu_regs.sv
module rmu_regs #(
  parameter int N_ENT     = 16,
  parameter int AW        = 32,
  parameter int ADDR_IMPL = 32,
  localparam int IW       = $clog2(N_ENT),
  localparam int BE_W     = (AW + 7) / 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_target,
  input  logic [IW-1:0]            wr_idx,
  input  logic [AW-1:0]            wr_data,
  input  logic [BE_W-1:0]          wr_be,
  output logic [N_ENT-1:0][7:0]    cfg_q,
  output logic [N_ENT-1:0][AW-1:0] addr_q
);
  localparam logic [AW-1:0] IMPL_MASK =
    (ADDR_IMPL >= AW) ? {AW{1'b1}} : AW'((64'd1 << ADDR_IMPL) - 64'd1);

  logic [AW-1:0] bit_en;
  always_comb begin
    for (int j = 0; j < AW; j++) bit_en[j] = wr_be[j / 8];
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam int WORD = e / 4;
    localparam int BYTE = e % 4;

    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[e] <= '0;
      end else if (wr_en && !wr_target && wr_idx == IW'(WORD) && wr_be[BYTE]) begin
        cfg_q[e] <= wr_data[8*BYTE +: 8];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        addr_q[e] <= '0;
      end else if (wr_en && wr_target && wr_idx == IW'(e)) begin
        addr_q[e] <= ((addr_q[e] & ~bit_en) | (wr_data & bit_en)) & IMPL_MASK;
      end
    end
  end
endmodule

// File: rtl/rmu_entry_match.sv
module rmu_entry_match
  import rmu_pkg::*;
#(
  parameter int AW = 32
) (
  input  amode_e        mode,
  input  logic [AW-1:0] hi,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] word_addr,
  output logic          match
);
  logic [AW-1:0] care;

  always_comb begin
    care = ~(hi ^ (hi + AW'(1)));
    unique case (mode)
      AM_TOR:   match = (word_addr >= lo) && (word_addr < hi);
      AM_NA4:   match = (word_addr == hi);
      AM_NAPOT: match = ((word_addr ^ hi) & care) == '0;
      default:  match = 1'b0;
    endcase
  end
endmodule

// File: rtl/rmu_prio.sv
module rmu_prio #(
  parameter int N_ENT = 16,
  localparam int IW   = $clog2(N_ENT)
) (
  input  logic [N_ENT-1:0] req,
  output logic             any,
  output logic [IW-1:0]    idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/region_match_unit.sv
module region_match_unit
  import rmu_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int PA_W      = 34,
  parameter int ADDR_IMPL = 32,
  localparam int AW       = PA_W - 2,
  localparam int IW       = $clog2(N_ENTRIES),
  localparam int BE_W     = (AW + 7) / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_target,
  input  logic [IW-1:0]        wr_idx,
  input  logic [AW-1:0]        wr_data,
  input  logic [BE_W-1:0]      wr_be,
  input  logic [PA_W-1:0]      lk_addr,
  output logic                 hit,
  output logic [IW-1:0]        hit_idx,
  output logic [7:0]           hit_cfg,
  output logic [N_ENTRIES-1:0] match_vec
);
  logic [N_ENTRIES-1:0][7:0]    cfg_q;
  logic [N_ENTRIES-1:0][AW-1:0] addr_q;
  logic [AW-1:0]                word_addr;
  logic                         unused_lsb;

  assign word_addr  = lk_addr[PA_W-1:2];
  assign unused_lsb = ^lk_addr[1:0];

  rmu_regs #(.N_ENT(N_ENTRIES), .AW(AW), .ADDR_IMPL(ADDR_IMPL)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_target(wr_target),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be),
    .cfg_q(cfg_q), .addr_q(addr_q)
  );

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_cmp
    logic [AW-1:0] lo;
    if (e == 0) begin : g_first
      assign lo = '0;
    end else begin : g_rest
      assign lo = addr_q[e-1];
    end
    rmu_entry_match #(.AW(AW)) u_match (
      .mode(mode_of(cfg_q[e])), .hi(addr_q[e]), .lo(lo),
      .word_addr(word_addr), .match(match_vec[e])
    );
  end

  rmu_prio #(.N_ENT(N_ENTRIES)) u_prio (
    .req(match_vec), .any(hit), .idx(hit_idx)
  );

  assign hit_cfg = hit ? cfg_q[hit_idx] : 8'h00;
endmodule

// File: rtl/rmu_checker.sv
module rmu_checker #(
  parameter int N_ENTRIES = 16,
  parameter int AW        = 32,
  localparam int IW       = $clog2(N_ENTRIES)
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         wr_en,
  input logic                         hit,
  input logic [IW-1:0]                hit_idx,
  input logic [7:0]                   hit_cfg,
  input logic [N_ENTRIES-1:0]         match_vec,
  input logic [N_ENTRIES-1:0][7:0]    cfg_q,
  input logic [N_ENTRIES-1:0][AW-1:0] addr_q
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!hit && match_vec == '0));

  a_r3_table_holds: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(addr_q) && $stable(cfg_q)));

  a_r9_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match_vec[hit_idx] &&
             (match_vec & ((N_ENTRIES'(1) << hit_idx) - N_ENTRIES'(1))) == '0));

  a_r9_cfg_follows: assert property (@(posedge clk) disable iff (rst)
    hit |-> hit_cfg == cfg_q[hit_idx]);

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (hit_idx == '0 && hit_cfg == 8'h00 && match_vec == '0));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    a_r4_off_quiet: assert property (@(posedge clk) disable iff (rst)
      cfg_q[e][4:3] == 2'd0 |-> !match_vec[e]);
    if (e > 0) begin : g_tor
      a_r6_empty_span: assert property (@(posedge clk) disable iff (rst)
        (cfg_q[e][4:3] == 2'd1 && addr_q[e-1] >= addr_q[e]) |-> !match_vec[e]);
    end
  end
endmodule

bind region_match_unit rmu_checker #(.N_ENTRIES(N_ENTRIES), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .hit(hit), .hit_idx(hit_idx),
  .hit_cfg(hit_cfg), .match_vec(match_vec), .cfg_q(cfg_q), .addr_q(addr_q)
);

// File: tb/sim_region_match_unit.sv
module sim_region_match_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, wr_target = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic [33:0] lk_addr = '0;
  logic        hit;
  logic [3:0]  hit_idx;
  logic [7:0]  hit_cfg;
  logic [15:0] match_vec;
  int nvec = 0, nbad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  region_match_unit u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_target(wr_target),
    .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be), .lk_addr(lk_addr),
    .hit(hit), .hit_idx(hit_idx), .hit_cfg(hit_cfg), .match_vec(match_vec)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic tgt, input logic [3:0] idx,
                    input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_target = tgt; wr_idx = idx; wr_data = d; wr_be = be;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic look(input string tag, input logic [33:0] a, input logic eh,
                      input logic [3:0] ei, input logic [7:0] ec, input logic [15:0] em);
    lk_addr = a;
    #1;
    chk({tag, " hit"}, 32'(hit), 32'(eh));
    chk({tag, " idx"}, 32'(hit_idx), 32'(ei));
    chk({tag, " cfg"}, 32'(hit_cfg), 32'(ec));
    chk({tag, " vec"}, 32'(match_vec), 32'(em));
  endtask

  task automatic t_reset;
    look("R1 reset", 34'h100, 0, 0, 8'h00, 16'h0);
  endtask

  task automatic t_tor;
    wr(1, 0, 32'h40, 4'hF);
    wr(0, 0, 32'h0B, 4'b0001);
    look("R5 entry0 low end", 34'h0, 1, 0, 8'h0B, 16'h0001);
    look("R5 entry0 top", 34'hFC, 1, 0, 8'h0B, 16'h0001);
    look("R5 entry0 excl", 34'h100, 0, 0, 8'h00, 16'h0);
    wr(1, 1, 32'h80, 4'hF);
    wr(0, 0, 32'hFFFF_09FF, 4'b0010);
    look("R2 byte enable kept entry0", 34'h4, 1, 0, 8'h0B, 16'h0001);
    look("R5 entry1 lower incl", 34'h100, 1, 1, 8'h09, 16'h0002);
    look("R5 entry1 top", 34'h1FC, 1, 1, 8'h09, 16'h0002);
    look("R5 entry1 excl", 34'h200, 0, 0, 8'h00, 16'h0);
  endtask

  task automatic t_tor_empty;
    wr(1, 2, 32'h10, 4'hF);
    wr(0, 0, 32'h0008_0000, 4'b0100);
    look("R6 empty span", 34'h140, 1, 1, 8'h09, 16'h0002);
    look("R6 below top", 34'h3C, 1, 0, 8'h0B, 16'h0001);
  endtask

  task automatic t_na4;
    wr(1, 6, 32'h1234, 4'hF);
    wr(0, 1, 32'h0010_0000, 4'b0100);
    look("R7 exact word", 34'h48D0, 1, 6, 8'h10, 16'h0040);
    look("R7 byte in word", 34'h48D3, 1, 6, 8'h10, 16'h0040);
    look("R7 next word", 34'h48D4, 0, 0, 8'h00, 16'h0);
  endtask

  task automatic t_napot;
    wr(1, 9, 32'hFFFF_2003, 4'b0011);
    wr(0, 2, 32'h0000_1800, 4'b0010);
    look("R8 base", 34'h8000, 1, 9, 8'h18, 16'h0200);
    look("R8 last", 34'h801C, 1, 9, 8'h18, 16'h0200);
    look("R8 above", 34'h8020, 0, 0, 8'h00, 16'h0);
    look("R8 below", 34'h7FFC, 0, 0, 8'h00, 16'h0);
  endtask

  task automatic t_prio;
    wr(1, 12, 32'h2001, 4'hF);
    wr(0, 3, 32'h18, 4'b0001);
    look("R9 R10 overlap", 34'h8004, 1, 9, 8'h18, 16'h1200);
    look("R8 R10 outer only", 34'h8014, 1, 9, 8'h18, 16'h0200);
    wr(0, 2, 32'h0, 4'b0010);
    look("R9 after disable", 34'h8004, 1, 12, 8'h18, 16'h1000);
    look("R4 disabled entry", 34'h8014, 0, 0, 8'h00, 16'h0);
    wr(1, 13, 32'h5000, 4'hF);
    look("R4 off with addr", 34'h14000, 0, 0, 8'h00, 16'h0);
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    wr_en = 1'b1; wr_target = 1'b1; wr_idx = 4'd12; wr_data = 32'h3001; wr_be = 4'hF;
    lk_addr = 34'hC000;
    #1;
    chk("R11 before edge hit", 32'(hit), 32'd0);
    chk("R11 before edge vec", 32'(match_vec), 32'h0);
    @(posedge clk);
    #1 wr_en = 1'b0;
    chk("R11 after edge hit", 32'(hit), 32'd1);
    chk("R11 after edge idx", 32'(hit_idx), 32'd12);
    chk("R3 R11 after edge vec", 32'(match_vec), 32'h1000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_tor();
    t_tor_empty();
    t_na4();
    t_napot();
    t_prio();
    t_same_cycle();
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    nvec++;
    nbad++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule